// File: doc/BRIEF.md
# Variable-Latency Execute Pipeline Controller

This block tracks the timing of an in-order five-stage pipeline: fetch, decode, operand read, execute and writeback. It does no arithmetic and holds no register values. It takes one decoded instruction per handshake. Each instruction carries an operation class, a destination register and two source registers. Every cycle the block reports which stages are occupied, which stages are holding their instruction, why the pipeline is stalled, when an instruction retires and how many cycles have passed since reset.

The execute stage is a single, non-pipelined unit. It stays busy for a number of cycles set by the operation class. Results are forwarded, so an instruction that needs a result can read its operands in the cycle right after the producer's last execute cycle. That read happens in the same cycle as the producer's writeback. Any stall freezes every stage in front of it, and instructions never pass one another.

Top module: `vlat_pipe_ctl`

## Requirements
- R1: During reset and in the first cycle after it, no stage is occupied, there is no retire pulse, the cycle count reads 0 and the input is ready.
- R2: Fetch, decode, operand read and writeback each hold an instruction for one cycle when nothing blocks it. An instruction accepted at a clock edge is in fetch in the next cycle. Without stalls it retires four cycles after that.
- R3: Operation code 0 (ADD) and 1 (SUB) occupy execute for LAT_ADD cycles (default 1). Code 2 (MUL) occupies it for LAT_MUL cycles (default 3). Code 3 (DIV) occupies it for LAT_DIV cycles (default 6).
- R4: There is only one execute unit. An instruction in operand read waits there while the unit is busy and will not finish this cycle. `unit_stall_o` is high in each such cycle.
- R5: An instruction waits in decode while either of its source registers matches the destination of an older instruction that is in operand read, or in execute and not in its last execute cycle. `raw_stall_o` is high while such a match exists. Register 0 is checked like any other register.
- R6: With forwarding, a dependent instruction enters operand read in the cycle right after its producer's last execute cycle.
- R7: A stage that holds its instruction makes every earlier occupied stage hold too. `instr_ready_o` is low exactly when fetch is holding, and instructions retire in the order they were accepted.
- R8: `retire_o` is high for exactly one cycle per instruction, in its writeback cycle, and `retire_dst_o` shows that instruction's destination.
- R9: `cycle_o` increases by one on every clock edge after reset.
- R10: Take the back-to-back sequence MUL r2,r0,r1; DIV r5,r3,r4; ADD r2,r5,r2; SUB r5,r2,r6, with the first one in fetch when the count reads 1. The last retire pulse then occurs when the count reads 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | An instruction is offered |
| instr_ready_o | output | 1 | The fetch stage can take the offered instruction |
| instr_op_i | input | 2 | Operation class: 0 ADD, 1 SUB, 2 MUL, 3 DIV |
| instr_dst_i | input | REG_W | Destination register |
| instr_src_a_i | input | REG_W | First source register |
| instr_src_b_i | input | REG_W | Second source register |
| occ_o | output | 5 | Stage occupancy: bit 0 fetch, 1 decode, 2 operand read, 3 execute, 4 writeback |
| hold_o | output | 4 | The stage keeps its instruction into the next cycle (bits 0..3 as for occ_o) |
| unit_stall_o | output | 1 | Operand read is waiting for the execute unit |
| raw_stall_o | output | 1 | Decode has an unresolved register dependency |
| retire_o | output | 1 | An instruction is in writeback this cycle |
| retire_dst_o | output | REG_W | Destination of the retiring instruction |
| cycle_o | output | CYC_W | Cycles since reset |

## Verification
The bench targets a dependent instruction whose producer finishes execute in exactly the cycle the dependency is resolved. A design that is off by one there either reads its operands a cycle early, which the forwarding rules forbid, or wastes a cycle. It also sends a long divide followed by independent instructions. A design that lets operand read overlap a busy unit shows two instructions executing at once, and one that fails to freeze upstream stages drops or duplicates instructions. Register 0 is used as both producer and consumer, which catches a design that skips it in the dependency check. Mixed sequences with gaps in the input catch a wrong ready signal, because it would accept an instruction in the wrong cycle and shift every retire after it.

// File: rtl/vlat_pkg.sv
package vlat_pkg;
  parameter int REG_W = 5;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src_a;
    logic [REG_W-1:0] src_b;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);
  localparam int N_FRONT = 3;  // fetch, decode, operand read
  localparam int N_PROD  = 2;  // producers still pending: operand read, execute
endpackage

// File: rtl/vlat_stage_reg.sv
module vlat_stage_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         clear_i,
  input  logic [W-1:0] d_i,
  output logic         v_o,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o <= 1'b0;
      q_o <= '0;
    end else if (load_i) begin
      v_o <= 1'b1;
      q_o <= d_i;
    end else if (clear_i) begin
      v_o <= 1'b0;
    end
  end
endmodule

// File: rtl/vlat_exec_unit.sv
module vlat_exec_unit #(
  parameter int W     = 5,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [W-1:0]     d_i,
  input  logic [CNT_W-1:0] lat_i,
  output logic             v_o,
  output logic [W-1:0]     q_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = v_o && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o   <= 1'b0;
      q_o   <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      v_o   <= 1'b1;
      q_o   <= d_i;
      cnt_q <= lat_i;
    end else if (done_o) begin
      v_o <= 1'b0;
    end else if (v_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/vlat_raw_check.sv
module vlat_raw_check
  import vlat_pkg::*;
#(
  parameter int NP = N_PROD
) (
  input  logic [NP-1:0]    busy_i,
  input  logic [REG_W-1:0] dst_i [NP],
  input  logic [REG_W-1:0] src_a_i,
  input  logic [REG_W-1:0] src_b_i,
  output logic             hz_o
);
  logic [NP-1:0] hit;

  for (genvar p = 0; p < NP; p++) begin : g_prod
    assign hit[p] = busy_i[p] && ((dst_i[p] == src_a_i) || (dst_i[p] == src_b_i));
  end

  assign hz_o = |hit;
endmodule

// File: rtl/vlat_pipe_ctl.sv
module vlat_pipe_ctl
  import vlat_pkg::*;
#(
  parameter int LAT_ADD = 1,
  parameter int LAT_MUL = 3,
  parameter int LAT_DIV = 6,
  parameter int CYC_W   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_valid_i,
  output logic             instr_ready_o,
  input  logic [1:0]       instr_op_i,
  input  logic [REG_W-1:0] instr_dst_i,
  input  logic [REG_W-1:0] instr_src_a_i,
  input  logic [REG_W-1:0] instr_src_b_i,
  output logic [4:0]       occ_o,
  output logic [3:0]       hold_o,
  output logic             unit_stall_o,
  output logic             raw_stall_o,
  output logic             retire_o,
  output logic [REG_W-1:0] retire_dst_o,
  output logic [CYC_W-1:0] cycle_o
);
  localparam int LAT_A = (LAT_ADD > LAT_MUL) ? LAT_ADD : LAT_MUL;
  localparam int LAT_MAX = (LAT_A > LAT_DIV) ? LAT_A : LAT_DIV;
  localparam int CNT_W = $clog2(LAT_MAX + 1);

  instr_t in_d;
  assign in_d = '{op: op_e'(instr_op_i), dst: instr_dst_i,
                  src_a: instr_src_a_i, src_b: instr_src_b_i};

  // front stages: fetch, decode, operand read
  logic [N_FRONT-1:0] fr_v, fr_load, fr_clear;
  logic [INSTR_W-1:0] fr_d   [N_FRONT];
  logic [INSTR_W-1:0] fr_raw [N_FRONT];
  instr_t             fr_q   [N_FRONT];

  logic in_fire, if_go, id_go, of_go;
  logic if_free, id_free, of_free;
  logic ex_v, ex_done, ex_free;
  logic [REG_W-1:0] ex_dst;
  logic [CNT_W-1:0] ex_lat;
  logic raw_hz;
  logic wb_v;
  logic [REG_W-1:0] wb_dst;

  for (genvar k = 0; k < N_FRONT; k++) begin : g_front
    if (k == 0) begin : g_head
      assign fr_d[k] = in_d;
    end else begin : g_link
      assign fr_d[k] = fr_q[k-1];
    end
    vlat_stage_reg #(.W(INSTR_W)) u_stg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (fr_load[k]),
      .clear_i(fr_clear[k]),
      .d_i    (fr_d[k]),
      .v_o    (fr_v[k]),
      .q_o    (fr_raw[k])
    );
    assign fr_q[k] = instr_t'(fr_raw[k]);
  end

  // advance chain, back to front
  assign ex_free = !ex_v || ex_done;
  assign of_go   = fr_v[2] && ex_free;
  assign of_free = !fr_v[2] || of_go;
  assign id_go   = fr_v[1] && of_free && !raw_hz;
  assign id_free = !fr_v[1] || id_go;
  assign if_go   = fr_v[0] && id_free;
  assign if_free = !fr_v[0] || if_go;
  assign in_fire = instr_valid_i && if_free;

  assign fr_load  = {id_go, if_go, in_fire};
  assign fr_clear = {of_go, id_go, if_go};

  // dependency check against operand read and unfinished execute
  logic [N_PROD-1:0] prod_busy;
  logic [REG_W-1:0]  prod_dst [N_PROD];
  assign prod_busy   = {ex_v && !ex_done, fr_v[2]};
  assign prod_dst[0] = fr_q[2].dst;
  assign prod_dst[1] = ex_dst;

  vlat_raw_check #(.NP(N_PROD)) u_raw (
    .busy_i (prod_busy),
    .dst_i  (prod_dst),
    .src_a_i(fr_q[1].src_a),
    .src_b_i(fr_q[1].src_b),
    .hz_o   (raw_hz)
  );

  always_comb begin
    case (fr_q[2].op)
      OP_MUL:  ex_lat = CNT_W'(LAT_MUL);
      OP_DIV:  ex_lat = CNT_W'(LAT_DIV);
      default: ex_lat = CNT_W'(LAT_ADD);
    endcase
  end

  vlat_exec_unit #(.W(REG_W), .CNT_W(CNT_W)) u_ex (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(of_go),
    .d_i   (fr_q[2].dst),
    .lat_i (ex_lat),
    .v_o   (ex_v),
    .q_o   (ex_dst),
    .done_o(ex_done)
  );

  // writeback always drains after one cycle
  vlat_stage_reg #(.W(REG_W)) u_wb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ex_done),
    .clear_i(1'b1),
    .d_i    (ex_dst),
    .v_o    (wb_v),
    .q_o    (wb_dst)
  );

  logic [CYC_W-1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else         cyc_q <= cyc_q + CYC_W'(1);
  end

  assign instr_ready_o = if_free;
  assign occ_o         = {wb_v, ex_v, fr_v};
  assign hold_o        = {ex_v && !ex_done, fr_v[2] && !of_go,
                          fr_v[1] && !id_go, fr_v[0] && !if_go};
  assign unit_stall_o  = fr_v[2] && !ex_free;
  assign raw_stall_o   = fr_v[1] && raw_hz;
  assign retire_o      = wb_v;
  assign retire_dst_o  = wb_dst;
  assign cycle_o       = cyc_q;
endmodule

// File: rtl/vlat_pipe_ctl_chk.sv
module vlat_pipe_ctl_chk #(
  parameter int CYC_W = 32,
  parameter int W     = 17,
  parameter int RW    = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             instr_ready_o,
  input logic [4:0]       occ_o,
  input logic [3:0]       hold_o,
  input logic             unit_stall_o,
  input logic             raw_stall_o,
  input logic             retire_o,
  input logic [CYC_W-1:0] cycle_o,
  input logic             ex_done_i,
  input logic [RW-1:0]    ex_dst_i,
  input logic [W-1:0]     of_q_i,
  input logic [W-1:0]     id_q_i
);
  a_r7_ready_low_on_if_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_o[0] && hold_o[0]) |-> !instr_ready_o);

  a_r7_ex_hold_freezes_of: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o[3] && occ_o[2]) |-> hold_o[2]);

  a_r3_ex_keeps_instr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o[3] |=> (occ_o[3] && $stable(ex_dst_i)));

  a_r4_of_waits_for_unit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_stall_o |=> (occ_o[2] && $stable(of_q_i)));

  a_r5_raw_holds_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_stall_o |=> (occ_o[1] && $stable(id_q_i)));

  a_r8_retire_after_last_ex: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_done_i |=> retire_o);

  a_r9_count_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((cycle_o - $past(cycle_o)) == CYC_W'(1)));
endmodule

bind vlat_pipe_ctl vlat_pipe_ctl_chk #(
  .CYC_W(CYC_W), .W(vlat_pkg::INSTR_W), .RW(vlat_pkg::REG_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .instr_ready_o(instr_ready_o),
  .occ_o        (occ_o),
  .hold_o       (hold_o),
  .unit_stall_o (unit_stall_o),
  .raw_stall_o  (raw_stall_o),
  .retire_o     (retire_o),
  .cycle_o      (cycle_o),
  .ex_done_i    (ex_done),
  .ex_dst_i     (ex_dst),
  .of_q_i       (fr_raw[2]),
  .id_q_i       (fr_raw[1])
);

// File: tb/vlat_pipe_ctl_tb.sv
module vlat_pipe_ctl_tb;
  import vlat_pkg::*;

  localparam int MAXN = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_v = 1'b0;
  logic [1:0] in_op = '0;
  logic [REG_W-1:0] in_dst = '0, in_sa = '0, in_sb = '0;
  logic in_rdy, u_stall, r_stall, ret;
  logic [4:0] occ;
  logic [3:0] hold;
  logic [REG_W-1:0] ret_dst;
  logic [31:0] cyc;

  always #2 clk = ~clk;  // 250 MHz

  vlat_pipe_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(in_v), .instr_ready_o(in_rdy),
    .instr_op_i(in_op), .instr_dst_i(in_dst), .instr_src_a_i(in_sa),
    .instr_src_b_i(in_sb), .occ_o(occ), .hold_o(hold), .unit_stall_o(u_stall),
    .raw_stall_o(r_stall), .retire_o(ret), .retire_dst_o(ret_dst), .cycle_o(cyc)
  );

  int n_chk = 0, n_fail = 0;
  int n;
  int p_op[MAXN], p_dst[MAXN], p_sa[MAXN], p_sb[MAXN], p_gap[MAXN];
  int t_off[MAXN], t_if[MAXN], t_id[MAXN], t_of[MAXN], t_ex[MAXN], t_xe[MAXN];
  int last_ret;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int lat(int op);
    return (op < 2) ? 1 : ((op == 2) ? 3 : 6);
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic put(int i, int op, int d, int a, int b, int g);
    p_op[i] = op; p_dst[i] = d; p_sa[i] = a; p_sb[i] = b; p_gap[i] = g;
  endtask

  // timing model: each instruction's stage entry cycles
  task automatic plan_times();
    for (int i = 0; i < n; i++) begin
      t_off[i] = (i == 0) ? p_gap[0] : t_if[i-1] + p_gap[i];
      t_if[i]  = (i == 0) ? t_off[i] + 1 : imax(t_off[i] + 1, t_id[i-1]);
      t_id[i]  = (i == 0) ? t_if[i] + 1 : imax(t_if[i] + 1, t_of[i-1]);
      t_of[i]  = (i == 0) ? t_id[i] + 1 : imax(t_id[i] + 1, t_ex[i-1]);
      for (int p = 0; p < i; p++)
        if (p_dst[p] == p_sa[i] || p_dst[p] == p_sb[i]) t_of[i] = imax(t_of[i], t_xe[p] + 1);
      t_ex[i]  = (i == 0) ? t_of[i] + 1 : imax(t_of[i] + 1, t_xe[i-1] + 1);
      t_xe[i]  = t_ex[i] + lat(p_op[i]) - 1;
    end
  endtask

  function automatic int s_beg(int i, int s);
    case (s)
      0: return t_if[i];
      1: return t_id[i];
      2: return t_of[i];
      3: return t_ex[i];
      default: return t_xe[i] + 1;
    endcase
  endfunction

  function automatic int s_end(int i, int s);
    return (s == 4) ? t_xe[i] + 2 : ((s == 3) ? t_xe[i] + 1 : s_beg(i, s + 1));
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    in_v = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: state in the first cycle after reset
    chk("R1 occupancy", int'(occ), 0);
    chk("R1 retire", int'(ret), 0);
    chk("R1 cycle count", int'(cyc), 0);
    chk("R1 ready", int'(in_rdy), 1);
  endtask

  task automatic run_prog(string name);
    int k, last;
    do_reset();
    plan_times();
    last = t_xe[n-1] + 3;
    k = 0;
    last_ret = -1;
    for (int c = 0; c <= last; c++) begin
      int e_occ, e_hold, e_unit, e_raw, e_ret, e_dst;
      while (k < n && c >= t_if[k]) k++;
      if (k < n && c >= t_off[k]) begin
        in_v = 1'b1; in_op = 2'(p_op[k]); in_dst = REG_W'(p_dst[k]);
        in_sa = REG_W'(p_sa[k]); in_sb = REG_W'(p_sb[k]);
      end else begin
        in_v = 1'b0;
      end
      e_occ = 0; e_hold = 0; e_raw = 0; e_ret = 0; e_dst = 0;
      for (int i = 0; i < n; i++) begin
        for (int s = 0; s < 5; s++) begin
          if (s_beg(i, s) <= c && c < s_end(i, s)) begin
            e_occ |= (1 << s);
            if (s < 4 && c + 1 < s_end(i, s)) e_hold |= (1 << s);
          end
        end
        if (t_xe[i] + 1 == c) begin e_ret = 1; e_dst = p_dst[i]; end
        if (t_id[i] <= c && c < t_of[i])
          for (int p = 0; p < i; p++)
            if ((p_dst[p] == p_sa[i] || p_dst[p] == p_sb[i]) && t_of[p] <= c && c < t_xe[p])
              e_raw = 1;
      end
      e_unit = (e_hold >> 2) & 1;
      chk({"R2 R6 occupancy ", name}, int'(occ), e_occ);
      chk({"R7 hold ", name}, int'(hold), e_hold);
      chk({"R7 ready ", name}, int'(in_rdy), ((e_hold & 1) != 0) ? 0 : 1);
      chk({"R4 unit stall ", name}, int'(u_stall), e_unit);
      chk({"R5 raw stall ", name}, int'(r_stall), e_raw);
      chk({"R3 R8 retire ", name}, int'(ret), e_ret);
      if (e_ret != 0) chk({"R8 retire dst ", name}, int'(ret_dst), e_dst);
      chk({"R9 cycle ", name}, int'(cyc), c);
      if (ret) last_ret = int'(cyc);
      @(negedge clk);
    end
    in_v = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // independent one-cycle ops, back to back
    n = 4;
    put(0, 0, 1, 2, 3, 0); put(1, 1, 4, 5, 6, 0);
    put(2, 0, 7, 8, 9, 0); put(3, 1, 10, 11, 12, 0);
    run_prog("p1");
    chk("R2 last retire p1", last_ret, 8);

    // the four-instruction dependency sequence
    n = 4;
    put(0, 2, 2, 0, 1, 0); put(1, 3, 5, 3, 4, 0);
    put(2, 0, 2, 5, 2, 0); put(3, 1, 5, 2, 6, 0);
    run_prog("p2");
    chk("R10 final retire cycle", last_ret, 17);

    // long divide followed by independent work, with an input gap
    n = 4;
    put(0, 3, 1, 2, 3, 0); put(1, 0, 4, 5, 6, 0);
    put(2, 2, 7, 8, 9, 3); put(3, 1, 9, 10, 11, 0);
    run_prog("p3");

    // register 0 as producer and consumer
    n = 5;
    put(0, 0, 0, 1, 2, 0); put(1, 1, 3, 0, 4, 0);
    put(2, 2, 0, 5, 6, 2); put(3, 0, 7, 8, 0, 0);
    put(4, 3, 8, 0, 0, 0);
    run_prog("p4");

    // mixed sequences over a small register set
    for (int r = 0; r < 3; r++) begin
      n = 12;
      for (int i = 0; i < n; i++) begin
        int v[5];
        for (int j = 0; j < 5; j++) begin
          seed = seed * 32'd1103515245 + 32'd12345;
          v[j] = int'(seed[23:16]);
        end
        put(i, v[0] % 4, v[1] % 4, v[2] % 4, v[3] % 5, (v[4] % 5 == 0) ? 1 + v[4] % 3 : 0);
      end
      run_prog($sformatf("mix%0d", r));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule